// File: doc/BRIEF.md
# ADC Output Word Formatter

This block sits between the digital correction logic of a high-speed converter and its output pin drivers. Each cycle it may receive one 12-bit conversion result, a strobe saying the result is present, and two flags saying the analog input went past the top or the bottom of the full-scale range. From these it forms the word that goes to the pins.

Data flows through three steps in a fixed order. First, an over-range result is clipped to the top or the bottom code. Second, the code can be changed from offset binary to two's complement. Third, a scrambler can mix the least significant bit into every other bit, which breaks up signal-correlated energy on the upper pins. Two test patterns can replace the data entirely, so that a receiver can close timing on the interface. One pattern toggles the whole word between all ones and all zeros. The other copies one free-running PRBS7 bit onto every pin.

The result is registered with one cycle of latency, and the valid strobe travels alongside it.

Top module: `adc_word_fmt`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_word` and `out_ovr` are all zero.
- R2: `out_valid` equals `in_valid` delayed by one clock. A valid input updates `out_word` and `out_ovr` one clock later. When `in_valid` is low, both outputs hold their previous values.
- R3: With `fmt_twos`=0, `scramble_en`=0 and `pattern_sel`=00, an in-range `in_code` appears unchanged on `out_word`.
- R4: With `fmt_twos`=1, bit 11 of the word is inverted and bits 10..0 pass unchanged.
- R5: With `scramble_en`=1, each of bits 11..1 is XORed with bit 0 and bit 0 is unchanged. This step is applied after the format step, and applying it a second time restores the formatted word.
- R6: `in_ovr_hi`=1 replaces the code with all ones, and `in_ovr_lo`=1 replaces it with all zeros; if both are set, `in_ovr_hi` wins. The clipping happens before the format and scramble steps. `out_ovr` is 1 whenever either flag was set on the sample.
- R7: `pattern_sel` selects the output source: 00 is data, 01 is the toggle pattern, and 10 or 11 is the PRBS pattern. A test pattern ignores the format, scramble and over-range clipping settings. `out_ovr` still follows the over-range flags.
- R8: The toggle state flips on every valid sample in any mode. In toggle mode the word is all ones or all zeros, with successive toggle samples opposite. The first valid sample after reset gives all ones.
- R9: The PRBS generator is a 7-stage register s[6:0]. Its output bit is s[6], and its next state is {s[5:0], s[6]^s[5]}, which is the polynomial x^7+x^6+1 with a period of 127. That one bit is copied to all 12 output bits.
- R10: The PRBS generator advances on every valid sample, whatever the mode. Changing the mode never restarts it, and idle cycles do not advance it.
- R11: The PRBS register never holds all zeros after reset. If it ever does, it reloads a nonzero seed on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_code | input | 12 | Conversion result, offset binary |
| in_ovr_hi | input | 1 | Input exceeded the positive full scale |
| in_ovr_lo | input | 1 | Input exceeded the negative full scale |
| fmt_twos | input | 1 | 1: two's complement output, 0: offset binary |
| scramble_en | input | 1 | Enable the LSB scrambler |
| pattern_sel | input | 2 | 00 data, 01 toggle, 1x PRBS |
| out_valid | output | 1 | Output word valid |
| out_word | output | 12 | Word to the output pins |
| out_ovr | output | 1 | Over-range flag aligned with out_word |

## Verification
The bench targets four kinds of mistake.

- The order of clipping, format and scramble. An over-range sample in two's complement with scrambling on must give the scrambled, sign-flipped limit code. A design that clips late, or scrambles before formatting, produces a different word.
- Both over-range flags raised at once. A design with the wrong priority clips to zeros instead of ones.
- The PRBS stream. It is aligned by shift-and-compare against a reference and then checked bit by bit across more than one period. The bench then spends valid samples in data mode and inserts idle cycles before returning to PRBS. A generator that restarts on a mode change, freezes outside PRBS mode, or steps on idle cycles then falls out of alignment.
- Hold behaviour during idle cycles. A design that lets the word follow the input without the strobe changes `out_word` while `in_valid` is low.

// File: rtl/adc_word_fmt.sv
module adc_word_fmt #(
  parameter int         W         = 12,
  parameter logic [6:0] PRBS_SEED = 7'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_code,
  input  logic         in_ovr_hi,
  input  logic         in_ovr_lo,
  input  logic         fmt_twos,
  input  logic         scramble_en,
  input  logic [1:0]   pattern_sel,
  output logic         out_valid,
  output logic [W-1:0] out_word,
  output logic         out_ovr
);

  localparam int LSTAGES = 7;

  logic [LSTAGES-1:0] prbs_q;
  logic               tog_q;
  logic [W-1:0]       next_word;

  wire prbs_fb  = prbs_q[LSTAGES-1] ^ prbs_q[LSTAGES-2];
  wire prbs_bit = prbs_q[LSTAGES-1];

  wire [W-1:0] clipped  = in_ovr_hi ? {W{1'b1}} : (in_ovr_lo ? {W{1'b0}} : in_code);
  wire [W-1:0] fmt_word = fmt_twos ? {~clipped[W-1], clipped[W-2:0]} : clipped;
  wire [W-1:0] scr_word = scramble_en ? (fmt_word ^ {{(W-1){fmt_word[0]}}, 1'b0}) : fmt_word;

  always_comb begin
    if (pattern_sel[1])      next_word = {W{prbs_bit}};
    else if (pattern_sel[0]) next_word = {W{~tog_q}};
    else                     next_word = scr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovr   <= 1'b0;
      tog_q     <= 1'b0;
      prbs_q    <= PRBS_SEED;
    end else begin
      out_valid <= in_valid;
      if (prbs_q == '0)
        prbs_q <= PRBS_SEED;
      else if (in_valid)
        prbs_q <= {prbs_q[LSTAGES-2:0], prbs_fb};
      if (in_valid) begin
        out_word <= next_word;
        out_ovr  <= in_ovr_hi | in_ovr_lo;
        tog_q    <= ~tog_q;
      end
    end
  end

endmodule

// File: rtl/adc_word_fmt_chk.sv
module adc_word_fmt_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] in_code,
  input logic         in_ovr_hi,
  input logic         in_ovr_lo,
  input logic         fmt_twos,
  input logic         scramble_en,
  input logic [1:0]   pattern_sel,
  input logic         out_valid,
  input logic [W-1:0] out_word,
  input logic         out_ovr,
  input logic [6:0]   prbs_q
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_ovr)));

  assert_ovr_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_ovr_hi || in_ovr_lo)) |=> out_ovr);

  assert_twos_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_twos && !scramble_en && pattern_sel == 2'b00 && !in_ovr_hi && !in_ovr_lo)
      |=> (out_word[W-1] == ~$past(in_code[W-1])));

  assert_pattern_uniform_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pattern_sel != 2'b00) |=> (out_word == '0 || out_word == '1));

  assert_prbs_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> prbs_q != 7'd0);

endmodule

bind adc_word_fmt adc_word_fmt_chk #(.W(W)) chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
  .in_ovr_hi(in_ovr_hi), .in_ovr_lo(in_ovr_lo), .fmt_twos(fmt_twos),
  .scramble_en(scramble_en), .pattern_sel(pattern_sel), .out_valid(out_valid),
  .out_word(out_word), .out_ovr(out_ovr), .prbs_q(prbs_q)
);

// File: tb/adc_word_fmt_test.sv
`timescale 1ns/1ps
module adc_word_fmt_test;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_code = '0;
  logic in_ovr_hi = 1'b0, in_ovr_lo = 1'b0;
  logic fmt_twos = 1'b0, scramble_en = 1'b0;
  logic [1:0] pattern_sel = 2'b00;
  logic out_valid, out_ovr;
  logic [W-1:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_word_fmt uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_code(in_code),
    .in_ovr_hi(in_ovr_hi), .in_ovr_lo(in_ovr_lo), .fmt_twos(fmt_twos),
    .scramble_en(scramble_en), .pattern_sel(pattern_sel),
    .out_valid(out_valid), .out_word(out_word), .out_ovr(out_ovr)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] step(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction

  function automatic logic [W-1:0] scr(input logic [W-1:0] v);
    logic [W-1:0] r = v;
    for (int i = 1; i < W; i++) r[i] = v[i] ^ v[0];
    return r;
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] c, input logic hi, input logic lo,
                                         input logic tw, input logic sc);
    logic [W-1:0] v;
    v = hi ? {W{1'b1}} : (lo ? {W{1'b0}} : c);
    if (tw) v[W-1] = ~v[W-1];
    if (sc) v = scr(v);
    return v;
  endfunction

  task automatic send(input logic [W-1:0] c, input logic hi, input logic lo);
    in_code = c; in_ovr_hi = hi; in_ovr_lo = lo; in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_valid", {11'd0, out_valid}, '0);
    check("R1 out_word", out_word, '0);
    check("R1 out_ovr", {11'd0, out_ovr}, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_toggle();
    logic [W-1:0] prev;
    pattern_sel = 2'b01; fmt_twos = 1'b1; scramble_en = 1'b1;
    send(12'h123, 1'b0, 1'b0);
    check("R8 first toggle all ones", out_word, '1);
    prev = out_word;
    for (int i = 0; i < 5; i++) begin
      send(12'h800 + 12'(i), 1'b0, 1'b1);
      check("R8 toggle alternates", out_word, ~prev);
      check("R7 ovr kept in pattern", {11'd0, out_ovr}, 12'd1);
      prev = out_word;
    end
    pattern_sel = 2'b00; fmt_twos = 1'b0; scramble_en = 1'b0;
  endtask

  task automatic t_data();
    logic [W-1:0] codes [6] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'h5A3, 12'h0C1};
    for (int m = 0; m < 4; m++) begin
      fmt_twos = m[0]; scramble_en = m[1];
      foreach (codes[i]) begin
        send(codes[i], 1'b0, 1'b0);
        check("R2 valid one cycle later", {11'd0, out_valid}, 12'd1);
        if (m == 0) check("R3 offset binary pass", out_word, codes[i]);
        if (m == 1) check("R4 twos complement", out_word, codes[i] ^ 12'h800);
        if (m >= 2) begin
          check("R5 scrambled word", out_word, model(codes[i], 1'b0, 1'b0, m[0], 1'b1));
          check("R5 descramble restores", scr(out_word), model(codes[i], 1'b0, 1'b0, m[0], 1'b0));
        end
      end
    end
    fmt_twos = 1'b0; scramble_en = 1'b0;
  endtask

  task automatic t_ovr();
    for (int m = 0; m < 4; m++) begin
      fmt_twos = m[0]; scramble_en = m[1];
      send(12'h456, 1'b1, 1'b0);
      check("R6 clip high", out_word, model(12'h456, 1'b1, 1'b0, m[0], m[1]));
      check("R6 ovr flag high", {11'd0, out_ovr}, 12'd1);
      send(12'h9AB, 1'b0, 1'b1);
      check("R6 clip low", out_word, model(12'h9AB, 1'b0, 1'b1, m[0], m[1]));
      send(12'h321, 1'b1, 1'b1);
      check("R6 high wins", out_word, model(12'h321, 1'b1, 1'b0, m[0], m[1]));
      send(12'h321, 1'b0, 1'b0);
      check("R6 ovr clears", {11'd0, out_ovr}, 12'd0);
    end
    fmt_twos = 1'b0; scramble_en = 1'b0;
  endtask

  task automatic t_hold();
    logic [W-1:0] prev;
    send(12'h3C5, 1'b1, 1'b0);
    prev = out_word;
    in_code = 12'hABC; in_ovr_hi = 1'b0;
    idle();
    check("R2 valid drops when idle", {11'd0, out_valid}, 12'd0);
    check("R2 word held when idle", out_word, prev);
    check("R2 ovr held when idle", {11'd0, out_ovr}, 12'd1);
  endtask

  task automatic t_prbs();
    logic hist [7];
    logic [6:0] rs, t, st;
    bit found, match;
    pattern_sel = 2'b10; fmt_twos = 1'b1; scramble_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      send(12'h0F0, 1'b1, 1'b0);
      check("R9 word uniform", (out_word == '0 || out_word == '1) ? 12'd1 : 12'd0, 12'd1);
      hist[i] = out_word[0];
    end
    rs = 7'h01; found = 1'b0; st = '0;
    for (int off = 0; off < 127 && !found; off++) begin
      t = rs; match = 1'b1;
      for (int i = 0; i < 7; i++) begin
        if (t[6] != hist[i]) match = 1'b0;
        t = step(t);
      end
      if (match) begin found = 1'b1; st = t; end
      rs = step(rs);
    end
    check("R9 alignment found", {11'd0, found}, 12'd1);
    for (int i = 0; i < 140; i++) begin
      pattern_sel = (i % 2 == 0) ? 2'b10 : 2'b11;
      send(12'(i), 1'b0, 1'b0);
      check("R9 prbs bit", out_word, {W{st[6]}});
      st = step(st);
    end
    pattern_sel = 2'b00;
    for (int i = 0; i < 5; i++) begin
      send(12'h111, 1'b0, 1'b0);
      st = step(st);
      idle();
    end
    pattern_sel = 2'b10;
    for (int i = 0; i < 20; i++) begin
      send(12'h222, 1'b0, 1'b0);
      check("R10 continues after mode change", out_word, {W{st[6]}});
      st = step(st);
    end
    check("R11 generator left nonzero", (st != 7'd0) ? 12'd1 : 12'd0, 12'd1);
    pattern_sel = 2'b00; fmt_twos = 1'b0; scramble_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_toggle();
    t_data();
    t_ovr();
    t_hold();
    t_prbs();
    idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule